// File: doc/BRIEF.md
# Virtual Address Translator with Fault Classifier

This block turns a 32-bit virtual address into a 29-bit physical address, or into a fault code, for an instruction fetch or a data read or write. It holds a 4-entry fully associative instruction lookaside buffer and a larger unified one (64 entries by default). Each entry has a page number, an address-space tag, a valid bit, a page size, a frame number, two protection bits, a dirty bit, a shared bit and a cacheable bit. Fixed untranslated windows of the address space are decoded in front of the buffers.

A fetch looks in the instruction buffer first. If it misses there, it looks in the unified buffer, and a hit there is copied into the least recently used instruction slot. Data accesses use only the unified buffer. The result is registered and appears one cycle after the request. On every fault except a multiple hit, the faulting page number is captured in a fault register. Entries are preloaded through a simple side write port.

Top module: `xlt_unit`

## Requirements
- R1: `rsp_vld` is high exactly in the cycle after a cycle with `req_vld` high, and low otherwise.
- R2: In privileged mode (`priv_md`=1), addresses 0x80000000–0xBFFFFFFF and 0xE0000000–0xFFFFFFFF always succeed with `rsp_paddr` = address bits 28:0, whatever the buffers hold.
- R3: With `priv_md`=0, an access to those windows outside 0xE0000000–0xE3FFFFFF gives code 0x0E0 for a fetch or a read and 0x100 for a data write. `req_wr` is ignored for fetches. Inside 0xE0000000–0xE3FFFFFF the access succeeds.
- R4: With `xlat_en`=0, any access outside the user-forbidden windows succeeds with `rsp_paddr` = address bits 28:0.
- R5: An entry matches only when it is valid and one of the following holds: its tag equals `cur_asid`, its shared bit is set, or `sv_mode`=1 with `priv_md`=1.
- R6: The size codes 0/1/2/3 select 1 KB/4 KB/64 KB/1 MB pages. The page base is the page number times 1 KB, aligned to the page size. `rsp_paddr` is the aligned frame base OR the in-page offset.
- R7: Two or more matching entries give code 0x140 and leave `flt_vpn` unchanged.
- R8: A data miss gives 0x040 for a read and 0x060 for a write. On a hit the checks run in this order: a user access to a page whose prot bit 1 is clear gives 0x0A0 for a read and 0x0C0 for a write; a write to a page whose prot bit 0 is clear gives 0x0C0; a write to a page whose dirty bit is clear gives 0x080. A successful access returns code 0.
- R9: When a fetch misses the instruction buffer and hits the unified one, the entry is copied into the instruction buffer. Later fetches of that page hit even after the unified entry has been invalidated. A user fetch from a page whose prot bit 1 is clear gives 0x0A0. A fetch that misses both buffers gives 0x040.
- R10: The instruction slot chosen for a refill is the one least recently hit or refilled.
- R11: On any fault except 0x140, `flt_vpn` is loaded with address bits 31:10. On success it holds its value.
- R12: `rsp_cache` is the matched entry's cacheable bit on a translated success, and 0 otherwise.
- R13: `ld_attr` bits are: [7] valid, [6:5] size, [4:3] prot, [2] dirty, [1] shared, [0] cacheable. `ld_itlb` selects the instruction buffer, and reset clears every valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Translation request |
| req_addr | input | 32 | Virtual address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data |
| req_wr | input | 1 | Data write (ignored for fetch) |
| priv_md | input | 1 | Privileged mode |
| xlat_en | input | 1 | Translation enable |
| sv_mode | input | 1 | Single-space mode (tag check off when privileged) |
| cur_asid | input | 8 | Current address-space tag |
| ld_en | input | 1 | Side write strobe |
| ld_itlb | input | 1 | Side write target: 1 = instruction buffer |
| ld_idx | input | 6 | Side write slot |
| ld_vpn | input | 22 | Entry page number |
| ld_asid | input | 8 | Entry tag |
| ld_ppn | input | 19 | Entry frame number |
| ld_attr | input | 8 | Entry attributes (see R13) |
| rsp_vld | output | 1 | Result valid |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_paddr | output | 29 | Physical address |
| rsp_code | output | 12 | Fault code, 0 on success |
| rsp_cache | output | 1 | Cacheable result |
| flt_vpn | output | 22 | Captured faulting page number |

## Verification
Every result (`rsp_ok`, `rsp_code`, `rsp_paddr`, `rsp_cache`, and the `flt_vpn` update) passes through one register. It is due at the first clock edge after the request. The bench drives a request at a falling edge, holds it through one rising edge, and reads all outputs at the next falling edge. Buffer state changes caused by a request (refill and recency update) take effect at that same edge. The next request therefore already sees them, and the replacement order is checked by later fetches that hit or miss.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
   localparam int VA_W   = 32;
   localparam int PA_W   = 29;
   localparam int PG_LSB = 10;
   localparam int VPN_W  = VA_W - PG_LSB;
   localparam int PPN_W  = PA_W - PG_LSB;
   localparam int ASID_W = 8;
   localparam int CODE_W = 12;

   typedef struct packed {
      logic [VPN_W-1:0]  vpn;
      logic [ASID_W-1:0] asid;
      logic              valid;
      logic [1:0]        size;
      logic [PPN_W-1:0]  ppn;
      logic [1:0]        prot;
      logic              dirty;
      logic              shared;
      logic              cache;
   } tlb_ent_t;

   localparam logic [CODE_W-1:0] C_NONE    = 12'h000;
   localparam logic [CODE_W-1:0] C_RD_MISS = 12'h040;
   localparam logic [CODE_W-1:0] C_WR_MISS = 12'h060;
   localparam logic [CODE_W-1:0] C_FIRSTWR = 12'h080;
   localparam logic [CODE_W-1:0] C_RD_VIOL = 12'h0A0;
   localparam logic [CODE_W-1:0] C_WR_VIOL = 12'h0C0;
   localparam logic [CODE_W-1:0] C_RD_AERR = 12'h0E0;
   localparam logic [CODE_W-1:0] C_WR_AERR = 12'h100;
   localparam logic [CODE_W-1:0] C_MULTI   = 12'h140;

   // page-number bits that take part in the compare for a size code
   function automatic logic [VPN_W-1:0] keep_mask(input logic [1:0] sz);
      logic [VPN_W-1:0] m;
      m = '1;
      case (sz)
         2'd0:    m = m;
         2'd1:    m[1:0] = '0;
         2'd2:    m[5:0] = '0;
         default: m[9:0] = '0;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/xlt_region.sv
module xlt_region
   import xlt_pkg::*;
(
   input  logic [VA_W-1:0] addr,
   input  logic            md,
   input  logic            at,
   output logic            bypass,
   output logic            aerr
);
   logic fixed_win, user_win;

   always_comb begin
      fixed_win = (addr[31:30] == 2'b10) || (addr[31:29] == 3'b111);
      user_win  = (addr[31:26] == 6'b111000);
      aerr      = fixed_win && !md && !user_win;
      bypass    = fixed_win || !at;
   end
endmodule

// File: rtl/xlt_cam.sv
module xlt_cam
   import xlt_pkg::*;
#(
   parameter  int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  tlb_ent_t          wr_ent,
   input  logic [VPN_W-1:0]  look_vpn,
   input  logic [ASID_W-1:0] look_asid,
   input  logic              asid_chk,
   output logic              hit,
   output logic              multi,
   output logic [IDX_W-1:0]  hit_idx,
   output tlb_ent_t          hit_ent
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("xlt_cam: DEPTH must be at least 2");
   end

   tlb_ent_t          mem [DEPTH];
   logic [DEPTH-1:0]  hv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= wr_ent;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      logic [VPN_W-1:0] km;
      assign km    = keep_mask(mem[g].size);
      assign hv[g] = mem[g].valid
                     && (((look_vpn ^ mem[g].vpn) & km) == '0)
                     && (!asid_chk || mem[g].shared || (mem[g].asid == look_asid));
   end

   always_comb begin
      hit_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (hv[i]) hit_idx = i[IDX_W-1:0];
      end
   end

   assign hit     = |hv;
   assign multi   = (hv & (hv - 1'b1)) != '0;
   assign hit_ent = mem[hit_idx];
endmodule

// File: rtl/xlt_lru.sv
module xlt_lru (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       touch,
   input  logic [1:0] touch_idx,
   output logic [1:0] victim
);
   // ord bit set => higher way of the pair used more recently
   // pairs: [5]=0/1 [4]=0/2 [3]=0/3 [2]=1/2 [1]=1/3 [0]=2/3
   logic [5:0] ord;
   logic [3:0] vict_oh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ord <= '0;
      end else if (touch) begin
         case (touch_idx)
            2'd0: begin ord[5] <= 1'b0; ord[4] <= 1'b0; ord[3] <= 1'b0; end
            2'd1: begin ord[5] <= 1'b1; ord[2] <= 1'b0; ord[1] <= 1'b0; end
            2'd2: begin ord[4] <= 1'b1; ord[2] <= 1'b1; ord[0] <= 1'b0; end
            default: begin ord[3] <= 1'b1; ord[1] <= 1'b1; ord[0] <= 1'b1; end
         endcase
      end
   end

   always_comb begin
      vict_oh[0] =  ord[5] &  ord[4] &  ord[3];
      vict_oh[1] = ~ord[5] &  ord[2] &  ord[1];
      vict_oh[2] = ~ord[4] & ~ord[2] &  ord[0];
      vict_oh[3] = ~ord[3] & ~ord[1] & ~ord[0];
      victim = vict_oh[1] ? 2'd1 : vict_oh[2] ? 2'd2 : vict_oh[3] ? 2'd3 : 2'd0;
   end

   // R10: exactly one way is ever the oldest
   p_victim_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(vict_oh));

   // R10: the way just used is never the next victim
   p_touched_not_victim_r10: assert property (@(posedge clk) disable iff (!rst_n)
      touch |=> victim != $past(touch_idx));
endmodule

// File: rtl/xlt_unit.sv
module xlt_unit
   import xlt_pkg::*;
#(
   parameter  int IT_N  = 4,
   parameter  int UT_N  = 64,
   localparam int UT_IW = $clog2(UT_N),
   localparam int IT_IW = $clog2(IT_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic [VA_W-1:0]   req_addr,
   input  logic              req_fetch,
   input  logic              req_wr,
   input  logic              priv_md,
   input  logic              xlat_en,
   input  logic              sv_mode,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic              ld_en,
   input  logic              ld_itlb,
   input  logic [UT_IW-1:0]  ld_idx,
   input  logic [VPN_W-1:0]  ld_vpn,
   input  logic [ASID_W-1:0] ld_asid,
   input  logic [PPN_W-1:0]  ld_ppn,
   input  logic [7:0]        ld_attr,
   output logic              rsp_vld,
   output logic              rsp_ok,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic [CODE_W-1:0] rsp_code,
   output logic              rsp_cache,
   output logic [VPN_W-1:0]  flt_vpn
);
   if (IT_N != 4) begin : g_bad_it
      $error("xlt_unit: recency tracker supports exactly 4 instruction slots");
   end
   if (UT_N < IT_N) begin : g_bad_ut
      $error("xlt_unit: unified buffer must be at least as deep as the instruction buffer");
   end

   tlb_ent_t           ld_ent, it_ent, ut_ent, sel, it_wr_ent;
   logic               it_hit, it_multi, ut_hit, ut_multi;
   logic [IT_IW-1:0]   it_hidx, victim, touch_idx, it_wr_idx;
   logic [UT_IW-1:0]   ut_hidx;
   logic               asid_chk, bypass, aerr, wr_eff;
   logic               ok, refill, touch, have, it_wr;
   logic [CODE_W-1:0]  code;
   logic [PA_W-1:0]    pa;
   logic               cch;
   logic [PPN_W-1:0]   pkm;

   assign ld_ent   = '{vpn: ld_vpn, asid: ld_asid, valid: ld_attr[7], size: ld_attr[6:5],
                       ppn: ld_ppn, prot: ld_attr[4:3], dirty: ld_attr[2],
                       shared: ld_attr[1], cache: ld_attr[0]};
   assign asid_chk = !(sv_mode && priv_md);
   assign wr_eff   = req_wr && !req_fetch;

   xlt_region u_region (.addr(req_addr), .md(priv_md), .at(xlat_en),
                        .bypass(bypass), .aerr(aerr));

   assign it_wr     = (ld_en && ld_itlb) || (req_vld && refill);
   assign it_wr_idx = (ld_en && ld_itlb) ? ld_idx[IT_IW-1:0] : victim;
   assign it_wr_ent = (ld_en && ld_itlb) ? ld_ent : ut_ent;

   xlt_cam #(.DEPTH(IT_N)) u_itlb (
      .clk(clk), .rst_n(rst_n), .wr_en(it_wr), .wr_idx(it_wr_idx), .wr_ent(it_wr_ent),
      .look_vpn(req_addr[VA_W-1:PG_LSB]), .look_asid(cur_asid), .asid_chk(asid_chk),
      .hit(it_hit), .multi(it_multi), .hit_idx(it_hidx), .hit_ent(it_ent));

   xlt_cam #(.DEPTH(UT_N)) u_utlb (
      .clk(clk), .rst_n(rst_n), .wr_en(ld_en && !ld_itlb), .wr_idx(ld_idx), .wr_ent(ld_ent),
      .look_vpn(req_addr[VA_W-1:PG_LSB]), .look_asid(cur_asid), .asid_chk(asid_chk),
      .hit(ut_hit), .multi(ut_multi), .hit_idx(ut_hidx), .hit_ent(ut_ent));

   xlt_lru u_lru (.clk(clk), .rst_n(rst_n), .touch(req_vld && touch),
                  .touch_idx(touch_idx), .victim(victim));

   always_comb begin
      ok        = 1'b0;
      code      = C_NONE;
      refill    = 1'b0;
      touch     = 1'b0;
      have      = 1'b0;
      touch_idx = it_hidx;
      sel       = ut_ent;
      cch       = 1'b0;
      pa        = req_addr[PA_W-1:0];
      if (aerr) begin
         code = wr_eff ? C_WR_AERR : C_RD_AERR;
      end else if (bypass) begin
         ok = 1'b1;
      end else if (req_fetch) begin
         if (it_multi) begin
            code = C_MULTI;
         end else if (it_hit) begin
            sel = it_ent; touch = 1'b1; have = 1'b1;
         end else if (ut_multi) begin
            code = C_MULTI;
         end else if (ut_hit) begin
            refill = 1'b1; touch = 1'b1; touch_idx = victim; have = 1'b1;
         end else begin
            code = C_RD_MISS;
         end
         if (have) begin
            if (!priv_md && !sel.prot[1]) code = C_RD_VIOL;
            else                          ok   = 1'b1;
         end
      end else begin
         if (ut_multi)                         code = C_MULTI;
         else if (!ut_hit)                     code = wr_eff ? C_WR_MISS : C_RD_MISS;
         else if (!priv_md && !sel.prot[1])    code = wr_eff ? C_WR_VIOL : C_RD_VIOL;
         else if (wr_eff && !sel.prot[0])      code = C_WR_VIOL;
         else if (wr_eff && !sel.dirty)        code = C_FIRSTWR;
         else                                  ok   = 1'b1;
      end
      pkm = keep_mask(sel.size)[PPN_W-1:0];
      if (ok && !bypass) begin
         pa  = {(sel.ppn & pkm) | (req_addr[PA_W-1:PG_LSB] & ~pkm), req_addr[PG_LSB-1:0]};
         cch = sel.cache;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld   <= 1'b0;
         rsp_ok    <= 1'b0;
         rsp_paddr <= '0;
         rsp_code  <= C_NONE;
         rsp_cache <= 1'b0;
         flt_vpn   <= '0;
      end else begin
         rsp_vld <= req_vld;
         if (req_vld) begin
            rsp_ok    <= ok;
            rsp_paddr <= pa;
            rsp_code  <= code;
            rsp_cache <= cch;
            if (!ok && code != C_MULTI) flt_vpn <= req_addr[VA_W-1:PG_LSB];
         end
      end
   end

   // R1: one-cycle result latency
   p_rsp_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_vld);
   p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !rsp_vld);
   // R3: user access to a forbidden fixed window is an address error
   p_user_aerr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && !priv_md && (req_addr[31:30] == 2'b10)
      |=> !rsp_ok && (rsp_code == C_RD_AERR || rsp_code == C_WR_AERR));
   // R4: translation off in privileged mode maps straight through
   p_xlat_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && !xlat_en && priv_md
      |=> rsp_ok && rsp_paddr == $past(req_addr[PA_W-1:0]));
   // R7: a multiple hit never disturbs the captured page number
   p_multi_keeps_vpn_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld && rsp_code == C_MULTI |-> $stable(flt_vpn));
   // R11: other faults capture the faulting page number
   p_fault_vpn_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld && !rsp_ok && rsp_code != C_MULTI
      |-> flt_vpn == $past(req_addr[VA_W-1:PG_LSB]));
   // R8: success carries no fault code
   p_ok_nocode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld && rsp_ok |-> rsp_code == C_NONE);
endmodule

// File: tb/tb_xlt_unit.sv
`timescale 1ns/1ps
module tb_xlt_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 0, req_fetch = 0, req_wr = 0, priv_md = 0, xlat_en = 0, sv_mode = 0;
   logic [31:0] req_addr = '0;
   logic [7:0]  cur_asid = '0;
   logic        ld_en = 0, ld_itlb = 0;
   logic [5:0]  ld_idx = '0;
   logic [21:0] ld_vpn = '0;
   logic [7:0]  ld_asid = '0;
   logic [18:0] ld_ppn = '0;
   logic [7:0]  ld_attr = '0;
   logic        rsp_vld, rsp_ok, rsp_cache;
   logic [28:0] rsp_paddr;
   logic [11:0] rsp_code;
   logic [21:0] flt_vpn;

   int checks = 0;
   int errors = 0;
   logic [21:0] exp_fv = '0;

   always #2 clk = ~clk;

   xlt_unit dut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic load(input logic it, input int idx, input logic [31:0] va,
                       input logic [7:0] asid, input logic [7:0] attr, input logic [31:0] pa);
      @(negedge clk);
      ld_en = 1; ld_itlb = it; ld_idx = idx[5:0]; ld_vpn = va[31:10];
      ld_asid = asid; ld_attr = attr; ld_ppn = pa[28:10];
      @(negedge clk);
      ld_en = 0;
   endtask

   task automatic req(input logic [31:0] a, input logic f, input logic w, input logic md,
                      input logic at, input logic sv, input logic [7:0] asid);
      @(negedge clk);
      req_vld = 1; req_addr = a; req_fetch = f; req_wr = w;
      priv_md = md; xlat_en = at; sv_mode = sv; cur_asid = asid;
      @(negedge clk);
      req_vld = 0;
   endtask

   task automatic expect_rsp(input string tag, input logic ok, input logic [11:0] code,
                             input logic [28:0] pa, input logic cache);
      chk({tag, " ok"}, rsp_ok, ok);
      chk({tag, " code"}, rsp_code, code);
      if (ok) chk({tag, " paddr"}, rsp_paddr, pa);
      chk({tag, " cache R12"}, rsp_cache, cache);
      if (!ok && code != 12'h140) exp_fv = req_addr[31:10];
      chk({tag, " fltvpn R11"}, flt_vpn, exp_fv);
   endtask

   // {req[91:88], addr, fetch, wr, md, at, sv, asid, ok, code, paddr, cache}
   localparam int NV = 22;
   localparam logic [91:0] VEC [NV] = '{
      {4'd6,  32'h00001010, 1'b0,1'b0,1'b1,1'b1,1'b0, 8'h11, 1'b1, 12'h000, 29'h01234410, 1'b1}, // R6 1K
      {4'd5,  32'h00001010, 1'b0,1'b0,1'b1,1'b1,1'b0, 8'h22, 1'b0, 12'h040, 29'h0,        1'b0}, // R5 tag mismatch
      {4'd5,  32'h00001010, 1'b0,1'b0,1'b1,1'b1,1'b1, 8'h22, 1'b1, 12'h000, 29'h01234410, 1'b1}, // R5 tag check off
      {4'd5,  32'h00001010, 1'b0,1'b0,1'b0,1'b1,1'b1, 8'h22, 1'b0, 12'h040, 29'h0,        1'b0}, // R5 user keeps check
      {4'd6,  32'h001ABCDE, 1'b0,1'b0,1'b0,1'b1,1'b0, 8'h33, 1'b1, 12'h000, 29'h0A0ABCDE, 1'b0}, // R6 1M shared
      {4'd8,  32'h001ABCDE, 1'b0,1'b1,1'b0,1'b1,1'b0, 8'h33, 1'b0, 12'h0C0, 29'h0,        1'b0}, // R8 read-only
      {4'd8,  32'h00201234, 1'b0,1'b0,1'b0,1'b1,1'b0, 8'h11, 1'b0, 12'h0A0, 29'h0,        1'b0}, // R8 user rd viol
      {4'd8,  32'h00201234, 1'b0,1'b1,1'b0,1'b1,1'b0, 8'h11, 1'b0, 12'h0C0, 29'h0,        1'b0}, // R8 viol before dirty
      {4'd8,  32'h00201234, 1'b0,1'b1,1'b1,1'b1,1'b0, 8'h11, 1'b0, 12'h080, 29'h0,        1'b0}, // R8 first write
      {4'd6,  32'h00201234, 1'b0,1'b0,1'b1,1'b1,1'b0, 8'h11, 1'b1, 12'h000, 29'h00311234, 1'b0}, // R6 64K
      {4'd13, 32'h00300004, 1'b0,1'b0,1'b1,1'b1,1'b0, 8'h11, 1'b0, 12'h040, 29'h0,        1'b0}, // R13 invalid entry
      {4'd8,  32'h00300004, 1'b0,1'b1,1'b1,1'b1,1'b0, 8'h11, 1'b0, 12'h060, 29'h0,        1'b0}, // R8 write miss
      {4'd2,  32'h9FFFFFFC, 1'b0,1'b0,1'b1,1'b1,1'b0, 8'h11, 1'b1, 12'h000, 29'h1FFFFFFC, 1'b0}, // R2
      {4'd3,  32'h80000010, 1'b0,1'b0,1'b0,1'b1,1'b0, 8'h11, 1'b0, 12'h0E0, 29'h0,        1'b0}, // R3 read
      {4'd3,  32'h80000010, 1'b0,1'b1,1'b0,1'b1,1'b0, 8'h11, 1'b0, 12'h100, 29'h0,        1'b0}, // R3 write
      {4'd3,  32'hE2000000, 1'b0,1'b1,1'b0,1'b1,1'b0, 8'h11, 1'b1, 12'h000, 29'h02000000, 1'b0}, // R3 user window
      {4'd3,  32'hE4000000, 1'b0,1'b0,1'b0,1'b1,1'b0, 8'h11, 1'b0, 12'h0E0, 29'h0,        1'b0}, // R3 past window
      {4'd4,  32'hC0000000, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h11, 1'b1, 12'h000, 29'h00000000, 1'b0}, // R4
      {4'd4,  32'h00001010, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h99, 1'b1, 12'h000, 29'h00001010, 1'b0}, // R4 ignores buffers
      {4'd2,  32'hA0001234, 1'b0,1'b1,1'b1,1'b1,1'b0, 8'h11, 1'b1, 12'h000, 29'h00001234, 1'b0}, // R2
      {4'd9,  32'h00001010, 1'b1,1'b0,1'b1,1'b1,1'b0, 8'h11, 1'b1, 12'h000, 29'h01234410, 1'b1}, // R9 refill
      {4'd3,  32'h80000000, 1'b1,1'b1,1'b0,1'b1,1'b0, 8'h11, 1'b0, 12'h0E0, 29'h0,        1'b0}  // R3 fetch ignores wr
   };

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog R1 act=hung exp=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R13 / R1 reset state
      chk("R1 reset vld", rsp_vld, 0);
      chk("R13 reset ok", rsp_ok, 0);
      chk("R11 reset fltvpn", flt_vpn, 0);
      rst_n = 1;
      @(negedge clk);
      // R13 attr {valid,size,prot,dirty,shared,cache}
      load(0, 0,  32'h00001000, 8'h11, 8'h9D, 32'h01234400);
      load(0, 1,  32'h00100000, 8'h55, 8'hF6, 32'h0A000000);
      load(0, 5,  32'h00200000, 8'h11, 8'hC8, 32'h00310000);
      load(0, 63, 32'h00300000, 8'h11, 8'h3D, 32'h00300000);

      for (int i = 0; i < NV; i++) begin
         logic [91:0] v;
         v = VEC[i];
         req(v[87:56], v[55], v[54], v[53], v[52], v[51], v[50:43]);
         chk($sformatf("R1 vec%0d vld", i), rsp_vld, 1);
         expect_rsp($sformatf("R%0d vec%0d", v[91:88], i), v[42], v[41:30], v[29:1], v[0]);
      end
      @(negedge clk);
      chk("R1 idle vld", rsp_vld, 0);

      // R7 multiple hit, fault page untouched
      load(0, 2, 32'h00001000, 8'h11, 8'h9D, 32'h01234400);
      req(32'h00001010, 0, 0, 1, 1, 0, 8'h11);
      expect_rsp("R7 data multi", 0, 12'h140, 0, 0);
      load(0, 2, 32'h00001000, 8'h11, 8'h00, 32'h0);

      // R9 / R10 refill and recency
      for (int k = 0; k < 5; k++)
         load(0, 10 + k, 32'h00400000 + k * 32'h1000, 8'h11, 8'hBD, 32'h00800000 + k * 32'h1000);
      for (int k = 0; k < 4; k++) begin
         req(32'h00400024 + k * 32'h1000, 1, 0, 1, 1, 0, 8'h11);
         expect_rsp("R9 fill", 1, 0, 29'h00800024 + k * 29'h1000, 1);
      end
      for (int k = 0; k < 4; k++)
         load(0, 10 + k, 32'h00400000 + k * 32'h1000, 8'h11, 8'h00, 32'h0);
      begin
         int ord [4] = '{2, 0, 3, 1};
         foreach (ord[j]) begin
            req(32'h00400024 + ord[j] * 32'h1000, 1, 0, 1, 1, 0, 8'h11);
            expect_rsp("R9 kept copy", 1, 0, 29'h00800024 + ord[j] * 29'h1000, 1);
         end
      end
      req(32'h00404024, 1, 0, 1, 1, 0, 8'h11);
      expect_rsp("R10 refill E", 1, 0, 29'h00804024, 1);
      req(32'h00402024, 1, 0, 1, 1, 0, 8'h11);
      expect_rsp("R10 LRU evicted", 0, 12'h040, 0, 0);
      begin
         int keep [3] = '{0, 1, 3};
         foreach (keep[j]) begin
            req(32'h00400024 + keep[j] * 32'h1000, 1, 0, 1, 1, 0, 8'h11);
            expect_rsp("R10 kept", 1, 0, 29'h00800024 + keep[j] * 29'h1000, 1);
         end
      end

      // R9 fetch violation, then privileged fetch hits
      load(0, 15, 32'h00500000, 8'h11, 8'hAD, 32'h00900000);
      req(32'h00500100, 1, 0, 0, 1, 0, 8'h11);
      expect_rsp("R9 fetch viol", 0, 12'h0A0, 0, 0);
      req(32'h00500100, 1, 0, 1, 1, 0, 8'h11);
      expect_rsp("R9 fetch priv", 1, 0, 29'h00900100, 1);

      // R7 fetch multiple hit in unified buffer
      load(0, 16, 32'h00700000, 8'h11, 8'hBD, 32'h00A00000);
      load(0, 17, 32'h00700000, 8'h11, 8'hBD, 32'h00A00000);
      req(32'h00700010, 1, 0, 1, 1, 0, 8'h11);
      expect_rsp("R7 fetch multi", 0, 12'h140, 0, 0);

      finish_run();
   end
endmodule